// File: doc/BRIEF.md
# Rotational Sector Position Generator

This block tracks the angular position of a head-per-track disk or drum. It has no rotating hardware of its own. A free-running strobe, `word_tick`, marks each word time, and the block keeps a word counter that wraps once per revolution. From that counter it derives four things for the surrounding controller:

- the sector number that will next pass under the heads;
- a late-in-sector phase flag;
- a one-word pulse at the start of every sector;
- a sticky flag showing that the track origin has gone by since software last asked for it to be watched.

One mode input selects the geometry. Disk mode has 90 sectors per track and drum mode has 32. Both use 64 words per sector. Each revolution begins with a 5-word overhead gap before the first sector's data.

The controller uses the next-sector number to schedule transfers and the sector pulse for coincidence. The two skip outputs give the results of the two diagnostic tests:

- "is the current sector still accessible";
- "has origin passed".

Both tests can only succeed in disk mode.

Top module: `rot_sector_gen`

## Requirements
- R1: After reset and until the next tick, the word position is 0, `next_sector` is 0, `scp_flag` and `sector_start` are 0, and `origin_seen` is 1.
- R2: A track lasts SECTORS×64+5 ticks. In disk mode that is 5765 ticks and in drum mode 2053 ticks. The position then returns to 0, which repeats the reset readings except `origin_seen`.
- R3: `next_sector` is 0 while the word position p is at most 5, including p=5.
- R4: In disk mode, for p>5, `next_sector` = (p−5)/64 + 1 using integer division. Its maximum is 90, reached at p=5764.
- R5: In drum mode, for p>5, `next_sector` = (p−5)/64. Its maximum is 31, reached at p=2052.
- R6: `scp_flag` is 1 exactly when p≥5 and (p−5) mod 64 is 61, 62 or 63. It is 0 throughout the gap.
- R7: `sector_start` is 1 exactly when p≥5 and (p−5) mod 64 = 0, for example p=5, 69 and 133.
- R8: When `word_tick` is low, the position does not advance and no output changes.
- R9: In disk mode, a cycle with `clear_origin` high clears `origin_seen` on the next clock. The flag sets again on the tick that wraps the position to 0. If both happen in the same cycle, the clear wins.
- R10: In drum mode, `clear_origin` has no effect on `origin_seen`.
- R11: `skip_clear_ok` equals disk mode AND NOT `scp_flag`. `skip_set_ok` equals disk mode AND `origin_seen`. In drum mode both are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| word_tick | input | 1 | One-cycle strobe per word time; advances the position |
| drum_mode | input | 1 | 1 selects drum geometry, 0 selects disk geometry |
| clear_origin | input | 1 | Arms origin detection (disk mode only) |
| next_sector | output | 7 | Number of the sector that will next pass under the heads |
| scp_flag | output | 1 | High during the last 3 words of a sector |
| sector_start | output | 1 | High during the first word of every sector |
| origin_seen | output | 1 | Track origin has passed since the last arm |
| skip_clear_ok | output | 1 | Result of the accessible-sector test |
| skip_set_ok | output | 1 | Result of the origin-passed test |

## Verification
The bench visits the boundaries of the sector count and checks each one:

- The last gap word, p=5. A design using `<` instead of `≤` there would already show sector 1 in disk mode.
- The first data word, p=6. Here the disk and drum numbering must differ by exactly one; omitting the mode-dependent offset shifts every drum sector.
- The three-word phase window at offsets 60, 61 and 63. An off-by-one error either widens the window or lets it overlap the sector pulse.
- The final word of the track, p=5764 in disk mode and p=2052 in drum mode, followed by the wrap tick. A wrong period length shows a nonzero sector right after the wrap or never re-sets the origin flag.

The origin tests cover several cases:

- arming in disk mode;
- arming in the same cycle as the wrap;
- arming in drum mode, which must leave the flag alone.

Stalls with no tick are also checked, to catch a counter that runs freely on the clock.

// File: rtl/rot_pkg.sv
// Package: shared geometry constants and helpers for the rotational
// position generator. Assumes words per sector is the same in both modes.
package rot_pkg;

    localparam int unsigned DEF_WORDS_PER_SECTOR = 64;
    localparam int unsigned DEF_DISK_SECTORS     = 90;
    localparam int unsigned DEF_DRUM_SECTORS     = 32;
    localparam int unsigned DEF_GAP_WORDS        = 5;
    localparam int unsigned DEF_PHASE_WORDS      = 3;

    // Track period in word times for a given sector count.
    function automatic int unsigned track_words(input int unsigned sectors,
                                                input int unsigned wps,
                                                input int unsigned gap);
        return sectors * wps + gap;
    endfunction

endpackage

// File: rtl/rot_track_counter.sv
// Module: rot_track_counter
// Counts word times around one revolution. Wraps to zero after the last
// word of the track; the period depends on the selected geometry.
// Assumes word_tick is a single-cycle strobe; reset is synchronous, active low.
module rot_track_counter #(
    parameter int unsigned WORDS_PER_SECTOR = rot_pkg::DEF_WORDS_PER_SECTOR,
    parameter int unsigned DISK_SECTORS     = rot_pkg::DEF_DISK_SECTORS,
    parameter int unsigned DRUM_SECTORS     = rot_pkg::DEF_DRUM_SECTORS,
    parameter int unsigned GAP_WORDS        = rot_pkg::DEF_GAP_WORDS,
    localparam int unsigned DISK_PERIOD = rot_pkg::track_words(DISK_SECTORS, WORDS_PER_SECTOR, GAP_WORDS),
    localparam int unsigned DRUM_PERIOD = rot_pkg::track_words(DRUM_SECTORS, WORDS_PER_SECTOR, GAP_WORDS),
    localparam int unsigned MAX_PERIOD  = (DISK_PERIOD > DRUM_PERIOD) ? DISK_PERIOD : DRUM_PERIOD,
    localparam int unsigned POS_W       = $clog2(MAX_PERIOD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_tick,
    input  logic             drum_mode,
    output logic [POS_W-1:0] pos,
    output logic             wrap_now
);

    localparam logic [POS_W-1:0] DISK_LAST = POS_W'(DISK_PERIOD - 1);
    localparam logic [POS_W-1:0] DRUM_LAST = POS_W'(DRUM_PERIOD - 1);

    logic [POS_W-1:0] last_pos;

    // Pick the final word position of the active geometry.
    always_comb begin
        last_pos = drum_mode ? DRUM_LAST : DISK_LAST;
    end

    // Wrap when a tick arrives at or past the end (>= covers a mode switch).
    always_comb begin
        wrap_now = word_tick && (pos >= last_pos);
    end

    // Advance the word position on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (wrap_now) begin
            pos <= '0;
        end else if (word_tick) begin
            pos <= pos + 1'b1;
        end
    end

endmodule

// File: rtl/rot_sector_decode.sv
// Module: rot_sector_decode
// Tracks the word offset within the current sector and the sector index,
// both held at zero through the track gap. Derives the next-sector number,
// the late-phase flag and the sector-start pulse. Assumes the counter
// position and wrap strobe come from rot_track_counter.
module rot_sector_decode #(
    parameter int unsigned WORDS_PER_SECTOR = rot_pkg::DEF_WORDS_PER_SECTOR,
    parameter int unsigned DISK_SECTORS     = rot_pkg::DEF_DISK_SECTORS,
    parameter int unsigned GAP_WORDS        = rot_pkg::DEF_GAP_WORDS,
    parameter int unsigned PHASE_WORDS      = rot_pkg::DEF_PHASE_WORDS,
    parameter int unsigned POS_W            = 13,
    localparam int unsigned OFS_W = $clog2(WORDS_PER_SECTOR),
    localparam int unsigned SEC_W = $clog2(DISK_SECTORS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_tick,
    input  logic             wrap_now,
    input  logic             drum_mode,
    input  logic [POS_W-1:0] pos,
    output logic [SEC_W-1:0] next_sector,
    output logic             scp_flag,
    output logic             sector_start
);

    localparam logic [POS_W-1:0] GAP_POS   = POS_W'(GAP_WORDS);
    localparam logic [OFS_W-1:0] OFS_LAST  = OFS_W'(WORDS_PER_SECTOR - 1);
    localparam logic [OFS_W-1:0] PHASE_MIN = OFS_W'(WORDS_PER_SECTOR - PHASE_WORDS);

    logic [OFS_W-1:0] word_ofs;
    logic [SEC_W-1:0] sec_idx;
    logic             in_data;

    // Step offset and index; both stay zero in the gap and on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_ofs <= '0;
            sec_idx  <= '0;
        end else if (word_tick) begin
            if (wrap_now || (pos < GAP_POS)) begin
                word_ofs <= '0;
                sec_idx  <= '0;
            end else if (word_ofs == OFS_LAST) begin
                word_ofs <= '0;
                sec_idx  <= sec_idx + 1'b1;
            end else begin
                word_ofs <= word_ofs + 1'b1;
            end
        end
    end

    // Decode flags and the one-ahead sector number from the counters.
    always_comb begin
        in_data      = (pos >= GAP_POS);
        sector_start = in_data && (word_ofs == '0);
        scp_flag     = in_data && (word_ofs >= PHASE_MIN);
        if (pos <= GAP_POS) begin
            next_sector = '0;
        end else begin
            next_sector = sec_idx + (drum_mode ? SEC_W'(0) : SEC_W'(1));
        end
    end

endmodule

// File: rtl/rot_origin_latch.sv
// Module: rot_origin_latch
// Sticky "origin passed" flag. Set by reset and by every track wrap;
// cleared by an arm request in disk mode only, which wins over a
// simultaneous wrap.
module rot_origin_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic drum_mode,
    input  logic clear_origin,
    input  logic wrap_now,
    output logic origin_seen
);

    // Hold, clear or set the origin flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            origin_seen <= 1'b1;
        end else if (clear_origin && !drum_mode) begin
            origin_seen <= 1'b0;
        end else if (wrap_now) begin
            origin_seen <= 1'b1;
        end
    end

endmodule

// File: rtl/rot_sector_gen.sv
// Module: rot_sector_gen (top)
// Rotational position generator for a head-per-track disk or drum.
// Combines the word counter, sector decode and origin latch, and forms
// the two diagnostic skip results. Assumes word_tick arrives at most once
// per clock and drum_mode is static during normal operation.
module rot_sector_gen #(
    parameter int unsigned WORDS_PER_SECTOR = rot_pkg::DEF_WORDS_PER_SECTOR,
    parameter int unsigned DISK_SECTORS     = rot_pkg::DEF_DISK_SECTORS,
    parameter int unsigned DRUM_SECTORS     = rot_pkg::DEF_DRUM_SECTORS,
    parameter int unsigned GAP_WORDS        = rot_pkg::DEF_GAP_WORDS,
    parameter int unsigned PHASE_WORDS      = rot_pkg::DEF_PHASE_WORDS,
    localparam int unsigned SEC_W = $clog2(DISK_SECTORS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_tick,
    input  logic             drum_mode,
    input  logic             clear_origin,
    output logic [SEC_W-1:0] next_sector,
    output logic             scp_flag,
    output logic             sector_start,
    output logic             origin_seen,
    output logic             skip_clear_ok,
    output logic             skip_set_ok
);

    localparam int unsigned DISK_PERIOD = rot_pkg::track_words(DISK_SECTORS, WORDS_PER_SECTOR, GAP_WORDS);
    localparam int unsigned DRUM_PERIOD = rot_pkg::track_words(DRUM_SECTORS, WORDS_PER_SECTOR, GAP_WORDS);
    localparam int unsigned MAX_PERIOD  = (DISK_PERIOD > DRUM_PERIOD) ? DISK_PERIOD : DRUM_PERIOD;
    localparam int unsigned POS_W       = $clog2(MAX_PERIOD);

    logic [POS_W-1:0] pos;
    logic             wrap_now;

    rot_track_counter #(
        .WORDS_PER_SECTOR (WORDS_PER_SECTOR),
        .DISK_SECTORS     (DISK_SECTORS),
        .DRUM_SECTORS     (DRUM_SECTORS),
        .GAP_WORDS        (GAP_WORDS)
    ) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_tick (word_tick),
        .drum_mode (drum_mode),
        .pos       (pos),
        .wrap_now  (wrap_now)
    );

    rot_sector_decode #(
        .WORDS_PER_SECTOR (WORDS_PER_SECTOR),
        .DISK_SECTORS     (DISK_SECTORS),
        .GAP_WORDS        (GAP_WORDS),
        .PHASE_WORDS      (PHASE_WORDS),
        .POS_W            (POS_W)
    ) u_decode (
        .clk          (clk),
        .rst_n        (rst_n),
        .word_tick    (word_tick),
        .wrap_now     (wrap_now),
        .drum_mode    (drum_mode),
        .pos          (pos),
        .next_sector  (next_sector),
        .scp_flag     (scp_flag),
        .sector_start (sector_start)
    );

    rot_origin_latch u_origin (
        .clk          (clk),
        .rst_n        (rst_n),
        .drum_mode    (drum_mode),
        .clear_origin (clear_origin),
        .wrap_now     (wrap_now),
        .origin_seen  (origin_seen)
    );

    // Diagnostic test results; drum geometry never reports success.
    always_comb begin
        skip_clear_ok = !drum_mode && !scp_flag;
        skip_set_ok   = !drum_mode && origin_seen;
    end

endmodule

// File: rtl/rot_sector_gen_chk.sv
// Module: rot_sector_gen_chk
// Temporal checks on the ports of rot_sector_gen, attached by bind.
module rot_sector_gen_chk #(
    parameter int unsigned SEC_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             word_tick,
    input logic             drum_mode,
    input logic             clear_origin,
    input logic [SEC_W-1:0] next_sector,
    input logic             scp_flag,
    input logic             sector_start,
    input logic             origin_seen,
    input logic             skip_clear_ok,
    input logic             skip_set_ok
);

    // R1: the cycle after reset shows origin passed and sector zero.
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (origin_seen && (next_sector == '0)));

    // R7: the sector pulse never overlaps the late-phase window.
    a_r7_start_not_late: assert property (@(posedge clk) disable iff (!rst_n)
        sector_start |-> !scp_flag);

    // R8: without a tick the phase outputs hold.
    a_r8_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !word_tick |=> ($stable(scp_flag) && $stable(sector_start)));

    // R9: arming in disk mode clears the flag on the next clock.
    a_r9_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_origin && !drum_mode) |=> !origin_seen);

    // R10: arming in drum mode leaves a set flag set.
    a_r10_drum_ignores_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_origin && drum_mode && origin_seen) |=> origin_seen);

    // R11: drum geometry never reports a successful test.
    a_r11_drum_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
        drum_mode |-> (!skip_clear_ok && !skip_set_ok));

endmodule

bind rot_sector_gen rot_sector_gen_chk #(.SEC_W(SEC_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .word_tick     (word_tick),
    .drum_mode     (drum_mode),
    .clear_origin  (clear_origin),
    .next_sector   (next_sector),
    .scp_flag      (scp_flag),
    .sector_start  (sector_start),
    .origin_seen   (origin_seen),
    .skip_clear_ok (skip_clear_ok),
    .skip_set_ok   (skip_set_ok)
);

// File: tb/test_rot_sector_gen.sv
module test_rot_sector_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       word_tick = 1'b0;
    logic       drum_mode = 1'b0;
    logic       clear_origin = 1'b0;
    logic [6:0] next_sector;
    logic       scp_flag, sector_start, origin_seen, skip_clear_ok, skip_set_ok;

    int checks = 0;
    int failures = 0;
    int cur_pos = 0;

    always #4 clk = ~clk;

    rot_sector_gen i_rot_sector_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .word_tick     (word_tick),
        .drum_mode     (drum_mode),
        .clear_origin  (clear_origin),
        .next_sector   (next_sector),
        .scp_flag      (scp_flag),
        .sector_start  (sector_start),
        .origin_seen   (origin_seen),
        .skip_clear_ok (skip_clear_ok),
        .skip_set_ok   (skip_set_ok)
    );

    // Disk-mode vectors: {position[15:0], next_sector[6:0], scp, start}
    localparam int NVEC = 10;
    localparam logic [24:0] DISK_VEC [NVEC] = '{
        {16'd0,    7'd0,  1'b0, 1'b0},   // R1 / R3
        {16'd4,    7'd0,  1'b0, 1'b0},   // R3 gap
        {16'd5,    7'd0,  1'b0, 1'b1},   // R3 last gap word, R7 start
        {16'd6,    7'd1,  1'b0, 1'b0},   // R4 first data word
        {16'd65,   7'd1,  1'b0, 1'b0},   // R6 offset 60
        {16'd66,   7'd1,  1'b1, 1'b0},   // R6 offset 61
        {16'd68,   7'd1,  1'b1, 1'b0},   // R6 offset 63
        {16'd69,   7'd2,  1'b0, 1'b1},   // R4 / R7 next sector
        {16'd133,  7'd3,  1'b0, 1'b1},   // R7
        {16'd5764, 7'd90, 1'b1, 1'b0}    // R4 maximum
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        word_tick = 1'b0;
        clear_origin = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        cur_pos = 0;
    endtask

    task automatic advance(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            word_tick = 1'b1;
        end
        @(negedge clk);
        word_tick = 1'b0;
        cur_pos = cur_pos + n;
    endtask

    initial begin : watchdog
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1 reset state in disk mode
        do_reset();
        check("R1 next_sector", next_sector, 0);
        check("R1 scp", scp_flag, 0);
        check("R1 start", sector_start, 0);
        check("R1 origin", origin_seen, 1);
        check("R11 skip_set after reset", skip_set_ok, 1);

        // Table walk in disk mode
        for (int i = 0; i < NVEC; i++) begin
            int target;
            target = int'(DISK_VEC[i][24:9]);
            if (target > cur_pos) advance(target - cur_pos);
            check("R4 table next_sector", next_sector, int'(DISK_VEC[i][8:2]));
            check("R6 table scp", scp_flag, int'(DISK_VEC[i][1]));
            check("R7 table start", sector_start, int'(DISK_VEC[i][0]));
            check("R11 table skip_clear", skip_clear_ok, int'(!DISK_VEC[i][1]));
        end

        // R8 stall at p=5764: no tick, nothing changes
        repeat (10) @(negedge clk);
        check("R8 stall next_sector", next_sector, 90);
        check("R8 stall scp", scp_flag, 1);

        // R9 arm in disk mode, then wrap sets origin
        clear_origin = 1'b1;
        @(negedge clk);
        clear_origin = 1'b0;
        check("R9 armed origin", origin_seen, 0);
        check("R11 skip_set when armed", skip_set_ok, 0);
        advance(1);
        cur_pos = 0;
        check("R2 disk wrap next_sector", next_sector, 0);
        check("R2 disk wrap start", sector_start, 0);
        check("R9 origin after wrap", origin_seen, 1);

        // R9 clear wins over a simultaneous wrap
        advance(5764);
        @(negedge clk);
        word_tick = 1'b1;
        clear_origin = 1'b1;
        @(negedge clk);
        word_tick = 1'b0;
        clear_origin = 1'b0;
        cur_pos = 0;
        check("R9 clear beats wrap", origin_seen, 0);
        check("R2 wrapped with clear", next_sector, 0);

        // Drum geometry
        drum_mode = 1'b1;
        do_reset();
        check("R11 drum skip_set", skip_set_ok, 0);
        check("R11 drum skip_clear", skip_clear_ok, 0);
        advance(5);
        check("R3 drum gap end", next_sector, 0);
        check("R7 drum start", sector_start, 1);
        advance(1);
        check("R5 drum first data", next_sector, 0);
        advance(63);
        check("R5 drum p69", next_sector, 1);
        check("R7 drum p69 start", sector_start, 1);
        // R10 arming ignored in drum mode
        clear_origin = 1'b1;
        @(negedge clk);
        clear_origin = 1'b0;
        check("R10 drum arm ignored", origin_seen, 1);
        advance(2052 - 69);
        check("R5 drum max", next_sector, 31);
        check("R6 drum last word scp", scp_flag, 1);
        advance(1);
        check("R2 drum wrap", next_sector, 0);
        check("R2 drum wrap scp", scp_flag, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule